// File: doc/BRIEF.md
# Ethernet Pause Flow Control Unit

This block handles pause-based flow control at the MAC layer for a single Ethernet port. It has two separate jobs. The first is to honour pause requests from the link partner. A decoded pause request carries a pause time in quanta. Each quantum is 512 bit times and is marked by a prescaled tick input. While that time runs, the block holds back normal data frames. A pause time of zero ends the hold at once.

The second job protects the local receive packet buffer. The block compares the buffer fill level against a high and a low watermark. From that it requests one outbound XOFF frame when the buffer fills, and one outbound XON frame once it has drained. These locally generated frames are never held back by a pause from the partner. Without that rule both ends could stall and the local buffer could overrun.

A small arbiter picks what the transmitter sends next. It only acts at frame boundaries, and a flow-control frame beats a waiting data frame. The arbiter issues a one-cycle start pulse with a frame kind and the pause time to encode. Framing, CRC and the physical layer sit outside.

Top module: `pause_flow_ctrl`

## Requirements
- R1: After reset no frame is started: `tx_go` is 0 and `tx_kind` is 0 (none) until a request arrives.
- R2: After a pause request with a nonzero time is taken in, no data frame (`tx_kind` = 1) is started while pause time remains.
- R3: The remaining pause time drops by one on each cycle with `quanta_tick` high. Data frames become eligible again in the cycle after the count reaches zero.
- R4: A pause request with a time of zero clears any remaining pause at once, acting as XON.
- R5: A pause request that arrives while a pause is running reloads the remaining time with the new value.
- R6: When `buf_level` >= `thr_xoff`, exactly one XOFF frame (`tx_kind` = 2) is started, carrying `local_pause_time`. No further XOFF is started until an XON has been sent. The inputs must keep `thr_xoff` > `thr_xon`.
- R7: Once an XOFF has been sent and `buf_level` < `thr_xon`, exactly one XON frame (`tx_kind` = 3) is started, with a pause time of 0. Levels in between start nothing.
- R8: XOFF and XON frames are started even while a received pause is holding data frames.
- R9: No frame is started while `tx_busy` is high. At a frame boundary, a waiting flow-control frame goes before a waiting data frame.
- R10: `tx_go` is a single-cycle pulse that never occurs in two consecutive cycles. `tx_kind` is nonzero exactly when `tx_go` is high. Kind codes are: 0 none, 1 data, 2 XOFF, 3 XON.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| quanta_tick | input | 1 | One-cycle pulse per 512 bit times |
| rx_pause_vld | input | 1 | Decoded pause request from the link partner |
| rx_pause_time | input | QUANTA_W | Pause time of that request in quanta (0 = resume) |
| buf_level | input | LEVEL_W | Receive packet buffer fill level |
| thr_xoff | input | LEVEL_W | High watermark that triggers XOFF |
| thr_xon | input | LEVEL_W | Low watermark that triggers XON |
| local_pause_time | input | QUANTA_W | Pause time to place in outbound XOFF frames |
| data_req | input | 1 | A normal data frame is waiting |
| tx_busy | input | 1 | Transmitter is sending a frame |
| tx_go | output | 1 | Start-of-frame pulse to the transmitter |
| tx_kind | output | 2 | Kind of frame to start (0 none, 1 data, 2 XOFF, 3 XON) |
| tx_pause_time | output | QUANTA_W | Pause time to encode in the started frame |

## Verification
A model transmitter holds `tx_busy` for a few cycles after every start, and a queue holds the frames the bench expects, in order.

The first pattern is data alone, which confirms plain grants. Next come partner pauses of several lengths, with ticks applied one at a time. These show the exact tick after which data resumes, and they separate a zero-time cancel from a reload in mid-pause. The buffer level then steps from below the low watermark, to between the two, to above the high one, and back down. This tells a single XOFF apart from repeats, and shows that no XON is sent at middle levels.

Finally, the level is raised while a data frame is in flight and while the partner pause holds data. These runs show that a flow-control frame waits for the frame boundary, then goes ahead of the remaining data, and is not blocked by the pause.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

   typedef enum logic [1:0] {
      FK_NONE = 2'd0,
      FK_DATA = 2'd1,
      FK_XOFF = 2'd2,
      FK_XON  = 2'd3
   } frame_kind_e;

   typedef enum logic [1:0] {
      WM_IDLE,
      WM_XOFF_PEND,
      WM_HELD,
      WM_XON_PEND
   } wm_state_e;

endpackage

// File: rtl/pfc_pause_timer.sv
module pfc_pause_timer #(
   parameter int QW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          load,
   input  logic [QW-1:0] load_val,
   output logic [QW-1:0] cnt_o,
   output logic          paused_o
);

   logic [QW-1:0] cnt_q;

   // a load always wins over a tick in the same cycle; zero load cancels
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (tick && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign cnt_o    = cnt_q;
   assign paused_o = (cnt_q != '0);

endmodule

// File: rtl/pfc_watermark.sv
module pfc_watermark
   import pfc_pkg::*;
#(
   parameter int LW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] level,
   input  logic [LW-1:0] thr_hi,
   input  logic [LW-1:0] thr_lo,
   input  logic          grant_xoff,
   input  logic          grant_xon,
   output logic          req_xoff,
   output logic          req_xon
);

   wm_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         WM_IDLE:      if (level >= thr_hi) state_d = WM_XOFF_PEND;
         WM_XOFF_PEND: if (grant_xoff)      state_d = WM_HELD;
         WM_HELD:      if (level < thr_lo)  state_d = WM_XON_PEND;
         WM_XON_PEND:  if (grant_xon)       state_d = WM_IDLE;
         default:                           state_d = WM_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= WM_IDLE;
      else        state_q <= state_d;
   end

   assign req_xoff = (state_q == WM_XOFF_PEND);
   assign req_xon  = (state_q == WM_XON_PEND);

endmodule

// File: rtl/pfc_tx_arbiter.sv
module pfc_tx_arbiter
   import pfc_pkg::*;
#(
   parameter int QW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_busy,
   input  logic          data_req,
   input  logic          paused,
   input  logic          req_xoff,
   input  logic          req_xon,
   input  logic [QW-1:0] local_time,
   output logic          grant_xoff,
   output logic          grant_xon,
   output logic          go_o,
   output logic [1:0]    kind_o,
   output logic [QW-1:0] time_o
);

   logic          go_q;
   frame_kind_e   kind_q, pick;
   logic [QW-1:0] time_q;
   logic          boundary;

   // one idle cycle after each start lets the transmitter raise busy
   assign boundary = !tx_busy && !go_q;

   always_comb begin
      if (req_xoff)                pick = FK_XOFF;
      else if (req_xon)            pick = FK_XON;
      else if (data_req && !paused) pick = FK_DATA;
      else                         pick = FK_NONE;
   end

   assign grant_xoff = boundary && (pick == FK_XOFF);
   assign grant_xon  = boundary && (pick == FK_XON);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         go_q   <= 1'b0;
         kind_q <= FK_NONE;
         time_q <= '0;
      end else if (boundary && (pick != FK_NONE)) begin
         go_q   <= 1'b1;
         kind_q <= pick;
         time_q <= (pick == FK_XOFF) ? local_time : '0;
      end else begin
         go_q   <= 1'b0;
         kind_q <= FK_NONE;
         time_q <= '0;
      end
   end

   assign go_o   = go_q;
   assign kind_o = kind_q;
   assign time_o = time_q;

endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl #(
   parameter int QUANTA_W = 16,
   parameter int LEVEL_W  = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                quanta_tick,
   input  logic                rx_pause_vld,
   input  logic [QUANTA_W-1:0] rx_pause_time,
   input  logic [LEVEL_W-1:0]  buf_level,
   input  logic [LEVEL_W-1:0]  thr_xoff,
   input  logic [LEVEL_W-1:0]  thr_xon,
   input  logic [QUANTA_W-1:0] local_pause_time,
   input  logic                data_req,
   input  logic                tx_busy,
   output logic                tx_go,
   output logic [1:0]          tx_kind,
   output logic [QUANTA_W-1:0] tx_pause_time
);

   if (QUANTA_W < 2) begin : g_bad_quanta_w
      $error("pause_flow_ctrl: QUANTA_W must be at least 2");
   end
   if (LEVEL_W < 2) begin : g_bad_level_w
      $error("pause_flow_ctrl: LEVEL_W must be at least 2");
   end

   logic [QUANTA_W-1:0] pause_cnt;
   logic                paused;
   logic                req_xoff, req_xon;
   logic                grant_xoff, grant_xon;

   pfc_pause_timer #(.QW(QUANTA_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (quanta_tick),
      .load     (rx_pause_vld),
      .load_val (rx_pause_time),
      .cnt_o    (pause_cnt),
      .paused_o (paused)
   );

   pfc_watermark #(.LW(LEVEL_W)) u_wm (
      .clk        (clk),
      .rst_n      (rst_n),
      .level      (buf_level),
      .thr_hi     (thr_xoff),
      .thr_lo     (thr_xon),
      .grant_xoff (grant_xoff),
      .grant_xon  (grant_xon),
      .req_xoff   (req_xoff),
      .req_xon    (req_xon)
   );

   pfc_tx_arbiter #(.QW(QUANTA_W)) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_busy    (tx_busy),
      .data_req   (data_req),
      .paused     (paused),
      .req_xoff   (req_xoff),
      .req_xon    (req_xon),
      .local_time (local_pause_time),
      .grant_xoff (grant_xoff),
      .grant_xon  (grant_xon),
      .go_o       (tx_go),
      .kind_o     (tx_kind),
      .time_o     (tx_pause_time)
   );

endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
   parameter int QW = 16,
   parameter int LW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_pause_vld,
   input logic [QW-1:0] rx_pause_time,
   input logic [LW-1:0] thr_xoff,
   input logic [LW-1:0] thr_xon,
   input logic          tx_busy,
   input logic          tx_go,
   input logic [1:0]    tx_kind,
   input logic [QW-1:0] tx_pause_time,
   input logic          paused,
   input logic [QW-1:0] pause_cnt
);

   AST_NO_DATA_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
      paused |=> !(tx_go && tx_kind == 2'd1));                               // R2

   AST_ZERO_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pause_vld && rx_pause_time == '0) |=> !paused);                    // R4

   AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pause_vld |=> (pause_cnt == $past(rx_pause_time)));                 // R5

   AST_THR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      thr_xoff > thr_xon);                                                   // R6

   AST_XON_TIME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_go && tx_kind == 2'd3) |-> (tx_pause_time == '0));                 // R7

   AST_NO_GO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_busy && !tx_go) |=> !tx_go);                                       // R9

   AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_go |=> !tx_go);                                                     // R10

   AST_KIND_WITH_GO: assert property (@(posedge clk) disable iff (!rst_n)
      tx_go == (tx_kind != 2'd0));                                           // R10

endmodule

bind pause_flow_ctrl pfc_checker #(.QW(QUANTA_W), .LW(LEVEL_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rx_pause_vld  (rx_pause_vld),
   .rx_pause_time (rx_pause_time),
   .thr_xoff      (thr_xoff),
   .thr_xon       (thr_xon),
   .tx_busy       (tx_busy),
   .tx_go         (tx_go),
   .tx_kind       (tx_kind),
   .tx_pause_time (tx_pause_time),
   .paused        (paused),
   .pause_cnt     (pause_cnt)
);

// File: tb/test_pause_flow_ctrl.sv
`timescale 1ns/1ps
module test_pause_flow_ctrl;

   localparam int QW = 16;
   localparam int LW = 12;
   localparam logic [QW-1:0] LOCAL_T = 16'h0040;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          quanta_tick = 1'b0;
   logic          rx_pause_vld = 1'b0;
   logic [QW-1:0] rx_pause_time = '0;
   logic [LW-1:0] buf_level = '0;
   logic [LW-1:0] thr_xoff = 12'd100;
   logic [LW-1:0] thr_xon = 12'd40;
   logic          data_req;
   logic          tx_busy;
   logic          tx_go;
   logic [1:0]    tx_kind;
   logic [QW-1:0] tx_pause_time;

   int checks = 0;
   int errors = 0;
   int n_data = 0, n_xoff = 0, n_xon = 0;
   int data_credit = 0;
   int busy_cnt = 0;
   logic [17:0] exp_q[$];

   always #2 clk = ~clk;   // 250 MHz

   assign data_req = (data_credit > 0);
   assign tx_busy  = (busy_cnt != 0);

   pause_flow_ctrl #(.QUANTA_W(QW), .LEVEL_W(LW)) i_pause_flow_ctrl (
      .clk              (clk),
      .rst_n            (rst_n),
      .quanta_tick      (quanta_tick),
      .rx_pause_vld     (rx_pause_vld),
      .rx_pause_time    (rx_pause_time),
      .buf_level        (buf_level),
      .thr_xoff         (thr_xoff),
      .thr_xon          (thr_xon),
      .local_pause_time (LOCAL_T),
      .data_req         (data_req),
      .tx_busy          (tx_busy),
      .tx_go            (tx_go),
      .tx_kind          (tx_kind),
      .tx_pause_time    (tx_pause_time)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic expect_frame(input logic [1:0] k, input logic [QW-1:0] t);
      exp_q.push_back({k, t});
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pause_rx(input logic [QW-1:0] t);
      @(negedge clk);
      rx_pause_vld  = 1'b1;
      rx_pause_time = t;
      @(negedge clk);
      rx_pause_vld  = 1'b0;
      rx_pause_time = '0;
   endtask

   task automatic tick_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         quanta_tick = 1'b1;
         @(negedge clk);
         quanta_tick = 1'b0;
      end
   endtask

   // transmitter model and scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && tx_go) begin
         logic [17:0] e;
         chk(!tx_busy, "R9 start while busy", 1, 0);
         if (exp_q.size() == 0) begin
            chk(1'b0, "R6/R10 unexpected frame kind", int'(tx_kind), 0);
         end else begin
            e = exp_q.pop_front();
            chk(tx_kind == e[17:16], "R10 frame kind order", int'(tx_kind), int'(e[17:16]));
            chk(tx_pause_time == e[15:0], "R6/R7 frame pause time",
                int'(tx_pause_time), int'(e[15:0]));
         end
         case (tx_kind)
            2'd1: begin n_data++; if (data_credit > 0) data_credit--; end
            2'd2: n_xoff++;
            2'd3: n_xon++;
            default: ;
         endcase
         busy_cnt = 3;
      end else if (busy_cnt != 0) begin
         busy_cnt--;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      cycles(5);
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(tx_go == 1'b0 && tx_kind == 2'd0, "R1 idle after reset", int'(tx_kind), 0);
      end

      // plain data
      expect_frame(2'd1, '0); expect_frame(2'd1, '0);
      data_credit = 2;
      cycles(20);
      chk(n_data == 2, "R10 plain data grants", n_data, 2);

      // pause of 3 quanta
      pause_rx(16'd3);
      expect_frame(2'd1, '0);
      data_credit = 1;
      cycles(20);
      chk(n_data == 2, "R2 data held by pause", n_data, 2);
      tick_n(2);
      cycles(10);
      chk(n_data == 2, "R3 held after 2 of 3 ticks", n_data, 2);
      tick_n(1);
      cycles(10);
      chk(n_data == 3, "R3 resumes after 3rd tick", n_data, 3);

      // zero time cancels
      pause_rx(16'd5);
      expect_frame(2'd1, '0);
      data_credit = 1;
      cycles(10);
      chk(n_data == 3, "R2 held by 5-quanta pause", n_data, 3);
      pause_rx(16'd0);
      cycles(10);
      chk(n_data == 4, "R4 zero time cancels pause", n_data, 4);

      // reload during pause
      pause_rx(16'd2);
      expect_frame(2'd1, '0);
      data_credit = 1;
      tick_n(1);
      pause_rx(16'd4);
      tick_n(3);
      cycles(10);
      chk(n_data == 4, "R5 reload keeps data held", n_data, 4);
      tick_n(1);
      cycles(10);
      chk(n_data == 5, "R5 resumes after reloaded time", n_data, 5);

      // watermarks while paused
      pause_rx(16'd7);
      data_credit = 2;
      expect_frame(2'd2, LOCAL_T);
      buf_level = 12'd120;
      cycles(30);
      chk(n_xoff == 1, "R8 XOFF sent while paused", n_xoff, 1);
      chk(n_data == 5, "R2 data still held", n_data, 5);
      buf_level = 12'd130;
      cycles(30);
      chk(n_xoff == 1, "R6 no repeated XOFF", n_xoff, 1);
      buf_level = 12'd60;
      cycles(20);
      chk(n_xon == 0, "R7 no XON between watermarks", n_xon, 0);
      expect_frame(2'd3, '0);
      buf_level = 12'd30;
      cycles(20);
      chk(n_xon == 1, "R7 one XON below low mark", n_xon, 1);
      expect_frame(2'd1, '0); expect_frame(2'd1, '0);
      pause_rx(16'd0);
      cycles(30);
      chk(n_data == 7, "R4 data after cancel", n_data, 7);

      // priority at frame boundary
      expect_frame(2'd1, '0);
      expect_frame(2'd2, LOCAL_T);
      expect_frame(2'd1, '0);
      expect_frame(2'd1, '0);
      data_credit = 3;
      wait (n_data == 8);
      buf_level = 12'd120;
      cycles(40);
      chk(n_data == 10, "R9 data after XOFF", n_data, 10);
      chk(n_xoff == 2, "R9 XOFF taken at boundary", n_xoff, 2);
      expect_frame(2'd3, '0);
      buf_level = 12'd0;
      cycles(20);
      chk(n_xon == 2, "R7 second XON", n_xon, 2);
      chk(exp_q.size() == 0, "R10 all expected frames seen", exp_q.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule